// File: doc/BRIEF.md
# Trap CSR Bank with Supervisor Views

This block is the register file for the interrupt and trap control registers of a small hart. It stores the machine-level status word, interrupt enable, pending and delegation words, scratch, exception PC, cause, trap value and trap-vector registers. It also serves the supervisor addresses. The supervisor status, enable and pending addresses are masked windows onto the machine storage, so they have no storage of their own. The supervisor scratch, exception PC, cause, trap value and trap vector are separate registers. A trigger-select location reads back the inverse of what was last written, which tells software that no triggers exist.

The pipeline reads through a combinational port addressed by the 12-bit CSR number. It writes through a port that commits on the next rising clock edge. Any read-modify-write that a CSR instruction needs is done outside the block. One configuration input states whether compressed instructions are on, and this sets how the exception PCs are aligned when they are read. Trap entry sequencing lies outside this block.

Top module: `trapcsr_bank`

## Requirements
- R1: After reset, every stored register reads zero, and the trigger-select address 0x7A0 reads all ones.
- R2: mscratch (0x340), sscratch (0x140), mcause (0x342), scause (0x142), mtval (0x343) and stval (0x143) each keep any written word unchanged, independently of each other.
- R3: mepc (0x341) and sepc (0x141) store the full written word. A read returns it with bit 0 cleared when compressed_en is 1, and with bits [1:0] cleared when compressed_en is 0.
- R4: In mtvec (0x305) and stvec (0x105), bits [XLEN-1:2] take any written value. The mode bits [1:0] accept only 00 and 01. A write carrying mode 10 or 11 keeps the previous mode but still updates the upper bits.
- R5: Writes to mstatus (0x300) change only bits 1, 3, 5, 7, 8, 11, 12, 18 and 19. All other bits read zero.
- R6: sstatus (0x100) reads mstatus ANDed with bits {1,5,8,18,19}. Writes through 0x100 change only those bits of mstatus.
- R7: mideleg (0x303) keeps only bits {1,5,9}. mie (0x304) keeps only bits {1,3,5,7,9,11}. Writes to mip (0x344) change only bits {1,5,9}.
- R8: sie (0x104) reads mie ANDed with mideleg. A write to 0x104 changes only the mie bits that are set in mideleg.
- R9: sip (0x144) reads mip ANDed with mideleg. A write to 0x144 changes only the mip bits that are set in mideleg.
- R10: A read of 0x7A0 returns the bitwise inverse of the last word written to 0x7A0.
- R11: A read of any other address returns zero with rd_unmapped at 1. rd_unmapped is 0 for every implemented address. A write to an unimplemented address changes no register.
- R12: The read port is combinational. A write becomes visible on the read port just after the rising edge on which wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| compressed_en | input | 1 | 1 when compressed instructions are enabled (2-byte PC alignment) |
| rd_addr | input | 12 | CSR number to read |
| rd_data | output | XLEN | Read value for rd_addr |
| rd_unmapped | output | 1 | High when rd_addr is not implemented |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | CSR number to write |
| wr_data | input | XLEN | Word to write |

## Verification
Since the read port is combinational, a wrong stored value shows up on rd_data during the first read of that address after the faulty edge. A write that escapes its field mask, or lands in the wrong alias, stays hidden until someone reads the other view of the same storage. For this reason every aliased write is followed by reads through both the machine address and the supervisor address. Alignment and mode legalization faults appear only for particular data patterns, so the stimulus sets the low bits on purpose and flips compressed_en between reads of one stored value.

// File: rtl/trapcsr_pkg.sv
package trapcsr_pkg;

  localparam logic [11:0] A_SSTATUS  = 12'h100;
  localparam logic [11:0] A_SIE      = 12'h104;
  localparam logic [11:0] A_STVEC    = 12'h105;
  localparam logic [11:0] A_SSCRATCH = 12'h140;
  localparam logic [11:0] A_SEPC     = 12'h141;
  localparam logic [11:0] A_SCAUSE   = 12'h142;
  localparam logic [11:0] A_STVAL    = 12'h143;
  localparam logic [11:0] A_SIP      = 12'h144;
  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MIDELEG  = 12'h303;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_TSEL     = 12'h7A0;

  // status fields kept: S-side {1,5,8,18,19}, plus M-side {3,7,11,12}
  localparam logic [31:0] STAT_S_MASK = 32'h000C_0122;
  localparam logic [31:0] STAT_M_MASK = 32'h000C_19AA;
  // interrupt lines: supervisor {1,5,9}, all {1,3,5,7,9,11}
  localparam logic [31:0] IRQ_S_MASK  = 32'h0000_0222;
  localparam logic [31:0] IRQ_ALL     = 32'h0000_0AAA;

  // plain word registers, index order used by the bank
  localparam int NWORD    = 9;
  localparam int W_MEPC   = 1;
  localparam int W_SEPC   = 5;
  localparam int W_TSEL   = 8;

  function automatic logic [11:0] word_addr(input int idx);
    case (idx)
      0:       return A_MSCRATCH;
      1:       return A_MEPC;
      2:       return A_MCAUSE;
      3:       return A_MTVAL;
      4:       return A_SSCRATCH;
      5:       return A_SEPC;
      6:       return A_SCAUSE;
      7:       return A_STVAL;
      default: return A_TSEL;
    endcase
  endfunction

  typedef enum logic [1:0] {
    TV_DIRECT   = 2'b00,
    TV_VECTORED = 2'b01
  } tvec_mode_e;

endpackage

// File: rtl/trapcsr_rst_sync.sv
module trapcsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/trapcsr_word.sv
module trapcsr_word #(
  parameter int          W    = 32,
  parameter logic [11:0] ADDR = 12'h000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic         load;
  logic [W-1:0] q_nxt;

  always_comb begin
    load  = wr_en && (wr_addr == ADDR);
    q_nxt = load ? wr_data : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_nxt;
  end
endmodule

// File: rtl/trapcsr_tvec.sv
module trapcsr_tvec
  import trapcsr_pkg::*;
#(
  parameter int          W    = 32,
  parameter logic [11:0] ADDR = 12'h305
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic         load;
  logic [W-3:0] base_q, base_nxt;
  logic [1:0]   mode_q, mode_nxt;

  always_comb begin
    load     = wr_en && (wr_addr == ADDR);
    base_nxt = wr_data[W-1:2];
    mode_nxt = mode_q;
    if (wr_data[1:0] == TV_DIRECT || wr_data[1:0] == TV_VECTORED)
      mode_nxt = wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= TV_DIRECT;
    end else if (load) begin
      base_q <= base_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign q = {base_q, mode_q};
endmodule

// File: rtl/trapcsr_status.sv
module trapcsr_status
  import trapcsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MMASK = W'(STAT_M_MASK);
  localparam logic [W-1:0] SMASK = W'(STAT_S_MASK);

  logic         load;
  logic [W-1:0] fmask;
  logic [W-1:0] q_nxt;

  always_comb begin
    fmask = '0;
    if (wr_en && wr_addr == A_MSTATUS) fmask = MMASK;
    if (wr_en && wr_addr == A_SSTATUS) fmask = SMASK;
    load  = |fmask;
    q_nxt = (q & ~fmask) | (wr_data & fmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_nxt;
  end
endmodule

// File: rtl/trapcsr_intr.sv
module trapcsr_intr
  import trapcsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] deleg_q,
  output logic [W-1:0] ie_q,
  output logic [W-1:0] ip_q
);
  localparam logic [W-1:0] SMASK = W'(IRQ_S_MASK);
  localparam logic [W-1:0] AMASK = W'(IRQ_ALL);

  logic         deleg_ld, ie_ld, ip_ld;
  logic [W-1:0] ie_fmask, ip_fmask;
  logic [W-1:0] deleg_nxt, ie_nxt, ip_nxt;

  always_comb begin
    ie_fmask = '0;
    ip_fmask = '0;
    if (wr_en && wr_addr == A_MIE) ie_fmask = AMASK;
    if (wr_en && wr_addr == A_SIE) ie_fmask = deleg_q & AMASK;
    if (wr_en && wr_addr == A_MIP) ip_fmask = SMASK;
    if (wr_en && wr_addr == A_SIP) ip_fmask = deleg_q & SMASK;
    deleg_ld  = wr_en && (wr_addr == A_MIDELEG);
    ie_ld     = |ie_fmask;
    ip_ld     = |ip_fmask;
    deleg_nxt = wr_data & SMASK;
    ie_nxt    = (ie_q & ~ie_fmask) | (wr_data & ie_fmask);
    ip_nxt    = (ip_q & ~ip_fmask) | (wr_data & ip_fmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deleg_q <= '0;
      ie_q    <= '0;
      ip_q    <= '0;
    end else begin
      if (deleg_ld) deleg_q <= deleg_nxt;
      if (ie_ld)    ie_q    <= ie_nxt;
      if (ip_ld)    ip_q    <= ip_nxt;
    end
  end
endmodule

// File: rtl/trapcsr_bank.sv
module trapcsr_bank
  import trapcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            compressed_en,
  input  logic [11:0]     rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_unmapped,
  input  logic            wr_en,
  input  logic [11:0]     wr_addr,
  input  logic [XLEN-1:0] wr_data
);
  localparam logic [XLEN-1:0] STAT_S = XLEN'(STAT_S_MASK);

  logic            rst_q_n;
  logic [XLEN-1:0] word_q [NWORD];
  logic [XLEN-1:0] status_q, deleg_q, ie_q, ip_q, mtvec_q, stvec_q;
  logic [XLEN-1:0] pc_mask;

  trapcsr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    trapcsr_word #(.W(XLEN), .ADDR(word_addr(g))) u_word (
      .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .q(word_q[g])
    );
  end

  trapcsr_tvec #(.W(XLEN), .ADDR(A_MTVEC)) u_mtvec (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .q(mtvec_q)
  );

  trapcsr_tvec #(.W(XLEN), .ADDR(A_STVEC)) u_stvec (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .q(stvec_q)
  );

  trapcsr_status #(.W(XLEN)) u_status (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .q(status_q)
  );

  trapcsr_intr #(.W(XLEN)) u_intr (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .deleg_q(deleg_q), .ie_q(ie_q), .ip_q(ip_q)
  );

  // exception PCs: 2-byte alignment with compressed code, 4-byte without
  assign pc_mask = compressed_en ? ~XLEN'(1) : ~XLEN'(3);

  always_comb begin
    rd_data     = '0;
    rd_unmapped = 1'b0;
    case (rd_addr)
      A_MSTATUS:  rd_data = status_q;
      A_SSTATUS:  rd_data = status_q & STAT_S;
      A_MIDELEG:  rd_data = deleg_q;
      A_MIE:      rd_data = ie_q;
      A_SIE:      rd_data = ie_q & deleg_q;
      A_MIP:      rd_data = ip_q;
      A_SIP:      rd_data = ip_q & deleg_q;
      A_MTVEC:    rd_data = mtvec_q;
      A_STVEC:    rd_data = stvec_q;
      A_MSCRATCH: rd_data = word_q[0];
      A_MEPC:     rd_data = word_q[W_MEPC] & pc_mask;
      A_MCAUSE:   rd_data = word_q[2];
      A_MTVAL:    rd_data = word_q[3];
      A_SSCRATCH: rd_data = word_q[4];
      A_SEPC:     rd_data = word_q[W_SEPC] & pc_mask;
      A_SCAUSE:   rd_data = word_q[6];
      A_STVAL:    rd_data = word_q[7];
      A_TSEL:     rd_data = ~word_q[W_TSEL];
      default:    rd_unmapped = 1'b1;
    endcase
  end
endmodule

// File: rtl/trapcsr_bank_chk.sv
module trapcsr_bank_chk
  import trapcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            compressed_en,
  input logic [11:0]     rd_addr,
  input logic [XLEN-1:0] rd_data,
  input logic            rd_unmapped,
  input logic            wr_en,
  input logic [11:0]     wr_addr,
  input logic [XLEN-1:0] wr_data
);
  localparam logic [XLEN-1:0] SBITS = XLEN'(IRQ_S_MASK);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_unmapped |-> rd_data == '0);

  assert_epc_align_c_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (compressed_en && (rd_addr == A_MEPC || rd_addr == A_SEPC)) |-> rd_data[0] == 1'b0);

  assert_epc_align_nc_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!compressed_en && (rd_addr == A_MEPC || rd_addr == A_SEPC)) |-> rd_data[1:0] == 2'b00);

  assert_tvec_mode_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_addr == A_MTVEC || rd_addr == A_STVEC) |-> rd_data[1] == 1'b0);

  assert_sie_window_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_addr == A_SIE) |-> (rd_data & ~SBITS) == '0);

  assert_sip_window_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_addr == A_SIP) |-> (rd_data & ~SBITS) == '0);

  assert_tsel_inverse_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_addr == A_TSEL) |=> (rd_addr == A_TSEL) -> rd_data == ~$past(wr_data));

  assert_scratch_keep_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_addr == A_MSCRATCH) |=> (rd_addr == A_MSCRATCH) -> rd_data == $past(wr_data));
endmodule

bind trapcsr_bank trapcsr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .compressed_en(compressed_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .rd_unmapped(rd_unmapped),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_trapcsr_bank.sv
`timescale 1ns/1ps
module tb_trapcsr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        compressed_en;
  logic [11:0] rd_addr;
  logic [31:0] rd_data;
  logic        rd_unmapped;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  trapcsr_bank #(.XLEN(32)) dut (
    .clk(clk), .rst_n(rst_n), .compressed_en(compressed_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_unmapped(rd_unmapped),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
    check(req, {31'd0, rd_unmapped}, 32'd0);
  endtask

  task automatic t_reset;
    rd_check("R1", 12'h300, 32'h0);
    rd_check("R1", 12'h304, 32'h0);
    rd_check("R1", 12'h305, 32'h0);
    rd_check("R1", 12'h141, 32'h0);
    rd_check("R1", 12'h7A0, 32'hFFFF_FFFF);
  endtask

  task automatic t_plain;
    wr(12'h340, 32'hDEAD_BEEF);
    wr(12'h140, 32'h1234_5678);
    wr(12'h343, 32'hFFFF_FFFF);
    wr(12'h143, 32'h0000_0001);
    wr(12'h342, 32'h8000_000B);
    wr(12'h142, 32'h0000_0005);
    rd_check("R2", 12'h340, 32'hDEAD_BEEF);
    rd_check("R2", 12'h140, 32'h1234_5678);
    rd_check("R2", 12'h343, 32'hFFFF_FFFF);
    rd_check("R2", 12'h143, 32'h0000_0001);
    rd_check("R2", 12'h342, 32'h8000_000B);
    rd_check("R2", 12'h142, 32'h0000_0005);
  endtask

  task automatic t_epc;
    wr(12'h341, 32'h8000_0003);
    wr(12'h141, 32'h0000_1237);
    compressed_en = 1'b1;
    rd_check("R3", 12'h341, 32'h8000_0002);
    rd_check("R3", 12'h141, 32'h0000_1236);
    compressed_en = 1'b0;
    rd_check("R3", 12'h341, 32'h8000_0000);
    rd_check("R3", 12'h141, 32'h0000_1234);
    compressed_en = 1'b1;
    rd_check("R3", 12'h341, 32'h8000_0002);
  endtask

  task automatic t_tvec;
    wr(12'h305, 32'h8000_0101);
    rd_check("R4", 12'h305, 32'h8000_0101);
    wr(12'h305, 32'h4000_0002);
    rd_check("R4", 12'h305, 32'h4000_0001);
    wr(12'h305, 32'h4000_0013);
    rd_check("R4", 12'h305, 32'h4000_0011);
    wr(12'h305, 32'h2000_0000);
    rd_check("R4", 12'h305, 32'h2000_0000);
    wr(12'h105, 32'h0000_1003);
    rd_check("R4", 12'h105, 32'h0000_1000);
    wr(12'h105, 32'h0000_2001);
    rd_check("R4", 12'h105, 32'h0000_2001);
  endtask

  task automatic t_status;
    wr(12'h300, 32'hFFFF_FFFF);
    rd_check("R5", 12'h300, 32'h000C_19AA);
    rd_check("R6", 12'h100, 32'h000C_0122);
    wr(12'h100, 32'h0000_0000);
    rd_check("R6", 12'h300, 32'h0000_1888);
    wr(12'h100, 32'hFFFF_FFFF);
    rd_check("R6", 12'h300, 32'h000C_19AA);
    wr(12'h300, 32'h0000_0000);
    rd_check("R5", 12'h300, 32'h0000_0000);
  endtask

  task automatic t_irq;
    wr(12'h303, 32'hFFFF_FFFF);
    rd_check("R7", 12'h303, 32'h0000_0222);
    wr(12'h304, 32'hFFFF_FFFF);
    rd_check("R7", 12'h304, 32'h0000_0AAA);
    wr(12'h344, 32'hFFFF_FFFF);
    rd_check("R7", 12'h344, 32'h0000_0222);
    wr(12'h344, 32'h0);
    // sie window with only bit 5 delegated
    wr(12'h303, 32'h0000_0020);
    rd_check("R8", 12'h104, 32'h0000_0020);
    wr(12'h104, 32'h0000_0000);
    rd_check("R8", 12'h304, 32'h0000_0A8A);
    wr(12'h104, 32'hFFFF_FFFF);
    rd_check("R8", 12'h304, 32'h0000_0AAA);
    wr(12'h303, 32'h0);
    rd_check("R8", 12'h104, 32'h0000_0000);
    // sip window with only bit 1 delegated
    wr(12'h303, 32'h0000_0002);
    wr(12'h144, 32'hFFFF_FFFF);
    rd_check("R9", 12'h344, 32'h0000_0002);
    wr(12'h344, 32'h0000_0222);
    rd_check("R9", 12'h144, 32'h0000_0002);
    wr(12'h144, 32'h0000_0000);
    rd_check("R9", 12'h344, 32'h0000_0220);
  endtask

  task automatic t_tsel;
    wr(12'h7A0, 32'h0000_000F);
    rd_check("R10", 12'h7A0, 32'hFFFF_FFF0);
    wr(12'h7A0, 32'hA5A5_0000);
    rd_check("R10", 12'h7A0, 32'h5A5A_FFFF);
  endtask

  task automatic t_unmapped;
    rd_addr = 12'h123;
    #1;
    check("R11", rd_data, 32'h0);
    check("R11", {31'd0, rd_unmapped}, 32'd1);
    rd_addr = 12'h7A1;
    #1;
    check("R11", {31'd0, rd_unmapped}, 32'd1);
    wr(12'h345, 32'hFFFF_FFFF);
    wr(12'h302, 32'hFFFF_FFFF);
    rd_check("R11", 12'h344, 32'h0000_0220);
    rd_check("R11", 12'h342, 32'h8000_000B);
    rd_check("R11", 12'h303, 32'h0000_0002);
  endtask

  task automatic t_timing;
    @(negedge clk);
    rd_addr = 12'h340; wr_en = 1'b1; wr_addr = 12'h340; wr_data = 32'h0BAD_F00D;
    #1;
    check("R12", rd_data, 32'hDEAD_BEEF);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R12", rd_data, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; compressed_en = 1'b1; rd_addr = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_plain;
    t_epc;
    t_tvec;
    t_status;
    t_irq;
    t_tsel;
    t_unmapped;
    t_timing;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule